// File: doc/BRIEF.md
# Cancelable Cache Line-Fill Controller

A direct-mapped read cache controller that sits between the memory stage of an in-order pipeline and a word-wide main-memory port. A read that hits returns its word in the following cycle, early enough to feed the address calculation of a dependent load. A read that misses issues one line request to memory and collects four single-word beats into a staging buffer. Tag, valid bit and data are written into the line only when the last beat arrives.

A protection fault in the pipeline reaches the controller as `cancel_i`, one cycle after the faulting read or later. A canceled read never returns data. With `SECURE=1` the cancel also aborts the memory side. A line request not yet issued is withdrawn, and a fill in progress is abandoned: its staging contents are discarded and later beats for it are ignored through a transaction tag. As a result, no tag, valid bit or data word differs from its value before the faulting read. With `SECURE=0` only the core response is suppressed, and the fill still completes and installs the line. This variant is kept for comparison. Both variants return the same data on every read that is not canceled.

Top module: `cfill_top`

## Requirements
- R1: Out of reset, `req_ready_o` is 1 and `rsp_valid_o` and `mem_req_valid_o` are 0; `req_ready_o` is 1 only when no miss is outstanding, and a read is taken when `req_valid_i` and `req_ready_o` are 1 and `cancel_i` is 0.
- R2: A read that hits raises `rsp_valid_o` in the next cycle with the addressed word and raises no memory request.
- R3: A read that misses raises `mem_req_valid_o` in the next cycle with `mem_req_addr_o` equal to the word address shifted right by 2 and a transaction tag on `mem_req_id_o`, held stable until `mem_req_ready_i`.
- R4: Fill beats carrying the outstanding tag are taken in order, beat k being word k (address bits [1:0]) of the line; the line is installed on the fourth beat and `rsp_valid_o` rises in the next cycle with the requested word, not earlier.
- R5: A beat whose `mem_rsp_id_i` differs from the outstanding fill's tag, or that arrives with no fill outstanding, changes neither the staging buffer nor the array.
- R6: `rsp_valid_o` is 0 in any cycle where `cancel_i` is 1, and a read canceled before its response never produces one later.
- R7: A read presented in the same cycle as `cancel_i` is dropped: no response and no memory request.
- R8: With `SECURE=1`, a cancel while a miss is outstanding withdraws `mem_req_valid_o` in that cycle, returns to idle so that `req_ready_o` is 1 in the next cycle, leaves every line as it was, and the next miss carries a different tag.
- R9: With `SECURE=1`, a cancel in the same cycle as a fill beat, including the fourth, wins: the beat is not stored and the line is not installed.
- R10: With `SECURE=0`, a canceled miss returns no response, but its fill runs to the end and the line is installed, so a later read of it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request from the memory stage |
| req_addr_i | input | ADDR_W | Word address of the read |
| req_ready_o | output | 1 | Controller idle, read can be taken |
| cancel_i | input | 1 | Exception flush from the protection logic |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | DATA_W | Read data |
| mem_req_valid_o | output | 1 | Line request to memory |
| mem_req_ready_i | input | 1 | Memory takes the line request |
| mem_req_addr_o | output | ADDR_W-2 | Line address |
| mem_req_id_o | output | ID_W | Transaction tag of the fill |
| mem_rsp_valid_i | input | 1 | Fill beat valid |
| mem_rsp_ready_o | output | 1 | Beat sink ready (always 1) |
| mem_rsp_id_i | input | ID_W | Transaction tag of the beat |
| mem_rsp_data_i | input | DATA_W | Fill beat word |

## Verification
The cancel can fall in the same cycle as three other events: the mem-request handshake, a fill beat, and the fourth beat that would install the line. It can also fall in the cycle that carries a hit response, or in the cycle of a new read. Each of these cases is provoked by raising `cancel_i` at a cycle counted from the request, against a memory model with fixed beat timing. Both variants run side by side on the same stimulus. The results are judged only at the ports: no response appears, the secure instance is ready one cycle later, earlier lines still hit with their old words, and a re-read of the canceled line misses in the secure variant but hits in the other.

// File: rtl/cfill_pkg.sv
`timescale 1ns/1ps
package cfill_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_FILL} fill_st_e;
endpackage

// File: rtl/cfill_store.sv
`timescale 1ns/1ps
module cfill_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 7,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_a [LINES];
  logic [DATA_W-1:0] dat_a [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q [WORDS];
    logic              sel;
    assign sel = we_i && (wr_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        for (int w = 0; w < WORDS; w++) d_q[w] <= '0;
      end else if (sel) begin
        v_q <= 1'b1;
        t_q <= wr_tag_i;
        for (int w = 0; w < WORDS; w++) d_q[w] <= wr_line_i[w*DATA_W +: DATA_W];
      end
    end

    assign vld[l]   = v_q;
    assign tag_a[l] = t_q;
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign dat_a[l][w] = d_q[w];
    end
  end

  assign hit_o     = vld[rd_idx_i] && (tag_a[rd_idx_i] == rd_tag_i);
  assign rd_word_o = dat_a[rd_idx_i][rd_off_i];

  // a written line must read back as present under its tag
  AST_WR_INSTALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vld[$past(wr_idx_i)] && tag_a[$past(wr_idx_i)] == $past(wr_tag_i))); // R4
endmodule

// File: rtl/cfill_stage.sv
`timescale 1ns/1ps
module cfill_stage #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] beat_data_i,
  output logic              last_o,
  output logic [LINE_W-1:0] line_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] buf_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int w = 0; w < WORDS; w++) buf_q[w] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (we_i) begin
      buf_q[cnt_q] <= beat_data_i;
      cnt_q        <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_W'(WORDS - 1));

  // current beat bypasses into its slot so the line is complete on the last beat
  for (genvar w = 0; w < WORDS; w++) begin : g_slot
    assign line_o[w*DATA_W +: DATA_W] = (cnt_q == CNT_W'(w)) ? beat_data_i : buf_q[w];
  end

  AST_STG_CLR_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && we_i)); // R9
endmodule

// File: rtl/cfill_ctrl.sv
`timescale 1ns/1ps
module cfill_ctrl import cfill_pkg::*; #(
  parameter bit SECURE = 1'b1,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ID_W   = 2,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cancel_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] hit_word_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-OFF_W-1:0] mem_req_addr_o,
  output logic [ID_W-1:0]   mem_req_id_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ID_W-1:0]   mem_rsp_id_i,
  input  logic              stg_last_i,
  input  logic [LINE_W-1:0] stg_line_i,
  output logic              stg_clr_o,
  output logic              stg_we_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] miss_addr_o
);
  fill_st_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   cur_id_q, nxt_id_q;
  logic              drop_q, rsp_q;
  logic [DATA_W-1:0] rsp_data_q, miss_word;
  logic accept, start, kill, beat_ok;

  assign accept  = (st_q == ST_IDLE) && req_valid_i && !cancel_i;
  assign start   = accept && !hit_i;
  assign kill    = SECURE && cancel_i && (st_q != ST_IDLE);
  assign beat_ok = (st_q == ST_FILL) && mem_rsp_valid_i && (mem_rsp_id_i == cur_id_q);

  assign stg_we_o  = beat_ok && !kill;
  assign wr_en_o   = stg_we_o && stg_last_i;
  assign stg_clr_o = start || kill;
  assign miss_word = stg_line_i[addr_q[OFF_W-1:0]*DATA_W +: DATA_W];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_MREQ;
      ST_MREQ: if (kill) st_d = ST_IDLE;
               else if (mem_req_ready_i) st_d = ST_FILL;
      ST_FILL: if (kill || wr_en_o) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      cur_id_q   <= '0;
      nxt_id_q   <= '0;
      drop_q     <= 1'b0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        addr_q   <= req_addr_i;
        cur_id_q <= nxt_id_q;
        nxt_id_q <= nxt_id_q + 1'b1;
      end
      if (start) drop_q <= 1'b0;
      else if (cancel_i && st_q != ST_IDLE) drop_q <= 1'b1;
      rsp_q <= (accept && hit_i) || (wr_en_o && !drop_q && !cancel_i);
      if (accept && hit_i) rsp_data_q <= hit_word_i;
      else if (wr_en_o)    rsp_data_q <= miss_word;
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign rsp_valid_o     = rsp_q && !cancel_i;
  assign rsp_data_o      = rsp_data_q;
  assign mem_req_valid_o = (st_q == ST_MREQ) && !kill;
  assign mem_req_addr_o  = addr_q[ADDR_W-1:OFF_W];
  assign mem_req_id_o    = cur_id_q;
  assign miss_addr_o     = addr_q;

  AST_HIT_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_i) |=> (rsp_valid_o || cancel_i)); // R2
  AST_MISS_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mem_req_valid_o || cancel_i)); // R3
  AST_MREQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i && !(SECURE && cancel_i))
      |=> ((mem_req_valid_o || (SECURE && cancel_i)) && $stable(mem_req_addr_o))); // R3
  AST_KILL_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SECURE && cancel_i && !req_ready_o) |=> req_ready_o); // R8
  AST_NO_INSTALL_ON_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SECURE && cancel_i) |-> !wr_en_o); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && req_valid_i && !wr_en_o) |=> !rsp_valid_o); // R1
endmodule

// File: rtl/cfill_top.sv
`timescale 1ns/1ps
module cfill_top #(
  parameter bit SECURE = 1'b1,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  input  logic              cancel_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-OFF_W-1:0] mem_req_addr_o,
  output logic [ID_W-1:0]   mem_req_id_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [ID_W-1:0]   mem_rsp_id_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  logic              hit, stg_last, stg_clr, stg_we, wr_en;
  logic [DATA_W-1:0] hit_word;
  logic [LINE_W-1:0] stg_line;
  logic [ADDR_W-1:0] miss_addr;

  assign mem_rsp_ready_o = 1'b1;

  cfill_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (req_addr_i[OFF_W +: IDX_W]),
    .rd_tag_i  (req_addr_i[ADDR_W-1 -: TAG_W]),
    .rd_off_i  (req_addr_i[OFF_W-1:0]),
    .hit_o     (hit),
    .rd_word_o (hit_word),
    .we_i      (wr_en),
    .wr_idx_i  (miss_addr[OFF_W +: IDX_W]),
    .wr_tag_i  (miss_addr[ADDR_W-1 -: TAG_W]),
    .wr_line_i (stg_line)
  );

  cfill_stage #(.WORDS(WORDS), .DATA_W(DATA_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (stg_clr),
    .we_i        (stg_we),
    .beat_data_i (mem_rsp_data_i),
    .last_o      (stg_last),
    .line_o      (stg_line)
  );

  cfill_ctrl #(.SECURE(SECURE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
               .ID_W(ID_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_addr_i      (req_addr_i),
    .cancel_i        (cancel_i),
    .hit_i           (hit),
    .hit_word_i      (hit_word),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_data_o      (rsp_data_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_id_o    (mem_req_id_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_id_i    (mem_rsp_id_i),
    .stg_last_i      (stg_last),
    .stg_line_i      (stg_line),
    .stg_clr_o       (stg_clr),
    .stg_we_o        (stg_we),
    .wr_en_o         (wr_en),
    .miss_addr_o     (miss_addr)
  );
endmodule

// File: tb/cfill_top_tb_top.sv
`timescale 1ns/1ps
module cfill_mem_model #(
  parameter int LA_W = 10,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            junk_first,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_line,
  input  logic [ID_W-1:0] req_id,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic [ID_W-1:0] rsp_id,
  output logic [31:0]     rsp_data
);
  initial begin
    logic [LA_W-1:0] line;
    logic [ID_W-1:0] id;
    req_ready = 1'b1; rsp_valid = 1'b0; rsp_id = '0; rsp_data = '0;
    @(negedge clk); #5;
    forever begin
      if (req_valid && req_ready) begin
        line = req_line; id = req_id;
        @(negedge clk); #5;
        req_ready = 1'b0;
        if (junk_first) begin
          rsp_valid = 1'b1; rsp_id = ID_W'(id + 1'b1); rsp_data = 32'hDEAD_BEEF;
          @(negedge clk); #5;
        end
        for (int k = 0; k < 4; k++) begin
          rsp_valid = 1'b1; rsp_id = id;
          rsp_data = 32'h5A00_0000 | (32'(line) << 4) | 32'(k);
          @(negedge clk); #5;
        end
        rsp_valid = 1'b0; req_ready = 1'b1;
      end else begin
        @(negedge clk); #5;
      end
    end
  end
endmodule

module cfill_top_tb_top;
  localparam int ADDR_W = 12;
  localparam int ID_W = 2;
  localparam int LA_W = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cancel = 1'b0, junk = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  int errors = 0, checks = 0;
  int s_rsp_cnt, v_rsp_cnt;

  logic s_ready, s_rsp_v, s_mreq_v, s_mreq_rdy, s_mrsp_v, s_mrsp_rdy;
  logic [31:0] s_rsp_d, s_mrsp_d;
  logic [LA_W-1:0] s_mreq_a;
  logic [ID_W-1:0] s_mreq_id, s_mrsp_id;
  logic v_ready, v_rsp_v, v_mreq_v, v_mreq_rdy, v_mrsp_v, v_mrsp_rdy;
  logic [31:0] v_rsp_d, v_mrsp_d;
  logic [LA_W-1:0] v_mreq_a;
  logic [ID_W-1:0] v_mreq_id, v_mrsp_id;

  always #10 clk = ~clk;

  cfill_top #(.SECURE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(s_ready), .cancel_i(cancel), .rsp_valid_o(s_rsp_v), .rsp_data_o(s_rsp_d),
    .mem_req_valid_o(s_mreq_v), .mem_req_ready_i(s_mreq_rdy), .mem_req_addr_o(s_mreq_a),
    .mem_req_id_o(s_mreq_id), .mem_rsp_valid_i(s_mrsp_v), .mem_rsp_ready_o(s_mrsp_rdy),
    .mem_rsp_id_i(s_mrsp_id), .mem_rsp_data_i(s_mrsp_d));

  cfill_top #(.SECURE(1'b0)) dut_v_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(v_ready), .cancel_i(cancel), .rsp_valid_o(v_rsp_v), .rsp_data_o(v_rsp_d),
    .mem_req_valid_o(v_mreq_v), .mem_req_ready_i(v_mreq_rdy), .mem_req_addr_o(v_mreq_a),
    .mem_req_id_o(v_mreq_id), .mem_rsp_valid_i(v_mrsp_v), .mem_rsp_ready_o(v_mrsp_rdy),
    .mem_rsp_id_i(v_mrsp_id), .mem_rsp_data_i(v_mrsp_d));

  cfill_mem_model #(.LA_W(LA_W), .ID_W(ID_W)) u_mem_s (
    .clk(clk), .junk_first(junk), .req_valid(s_mreq_v), .req_line(s_mreq_a), .req_id(s_mreq_id),
    .req_ready(s_mreq_rdy), .rsp_valid(s_mrsp_v), .rsp_id(s_mrsp_id), .rsp_data(s_mrsp_d));
  cfill_mem_model #(.LA_W(LA_W), .ID_W(ID_W)) u_mem_v (
    .clk(clk), .junk_first(junk), .req_valid(v_mreq_v), .req_line(v_mreq_a), .req_id(v_mreq_id),
    .req_ready(v_mreq_rdy), .rsp_valid(v_mrsp_v), .rsp_id(v_mrsp_id), .rsp_data(v_mrsp_d));

  function automatic logic [31:0] mdata(input logic [ADDR_W-1:0] a);
    return 32'h5A00_0000 | (32'(a[ADDR_W-1:2]) << 4) | 32'(a[1:0]);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input bit with_cancel);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; cancel = with_cancel;
    @(negedge clk);
    req_valid = 1'b0; cancel = 1'b0;
  endtask

  task automatic wait_idle();
    s_rsp_cnt = 0; v_rsp_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (s_rsp_v) s_rsp_cnt++;
      if (v_rsp_v) v_rsp_cnt++;
      if (s_ready && v_ready && s_mreq_rdy && v_mreq_rdy && !s_mrsp_v && !v_mrsp_v) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_sec_rsp(input logic [ADDR_W-1:0] a, input string tag);
    int n;
    n = 0;
    while (!s_rsp_v && n < 20) begin @(negedge clk); n++; end
    chk(s_rsp_v && s_rsp_d == mdata(a), tag, s_rsp_d, mdata(a));
    wait_idle();
  endtask

  task automatic do_miss(input logic [ADDR_W-1:0] a, input int extra, input string tag);
    send(a, 1'b0);
    chk(s_mreq_v && v_mreq_v, {tag, " R3 mem request raised"}, 32'(s_mreq_v), 1);
    chk(s_mreq_a == a[ADDR_W-1:2], {tag, " R3 line address"}, 32'(s_mreq_a), 32'(a[ADDR_W-1:2]));
    for (int i = 0; i < 4 + extra; i++) @(negedge clk);
    chk(!s_rsp_v, {tag, " R4 no response before last beat"}, 32'(s_rsp_v), 0);
    @(negedge clk);
    chk(s_rsp_v && s_rsp_d == mdata(a), {tag, " R4 secure fill word"}, s_rsp_d, mdata(a));
    chk(v_rsp_v && v_rsp_d == mdata(a), {tag, " R4 plain fill word"}, v_rsp_d, mdata(a));
    wait_idle();
  endtask

  task automatic do_hit(input logic [ADDR_W-1:0] a, input string tag);
    send(a, 1'b0);
    chk(s_rsp_v && s_rsp_d == mdata(a) && !s_mreq_v, {tag, " R2 secure hit"}, s_rsp_d, mdata(a));
    chk(v_rsp_v && v_rsp_d == mdata(a) && !v_mreq_v, {tag, " R2 plain hit"}, v_rsp_d, mdata(a));
    wait_idle();
  endtask

  task automatic check_snapshot(input string tag);
    do_hit(12'h005, {tag, " R8 line kept"});
    do_hit(12'h013, {tag, " R8 line kept"});
    do_hit(12'h02A, {tag, " R8 line kept"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(s_ready && !s_rsp_v && !s_mreq_v, "R1 reset state", {29'd0, s_ready, s_rsp_v, s_mreq_v}, 32'h4);
  endtask

  task automatic t_fill_and_hit();
    do_miss(12'h005, 0, "fill A");
    do_miss(12'h013, 0, "fill B");
    do_miss(12'h02A, 0, "fill C");
    do_hit(12'h004, "hit A0");
    do_hit(12'h007, "hit A3");
    do_hit(12'h012, "hit B2");
    do_hit(12'h029, "hit C1");
  endtask

  task automatic t_req_with_cancel();
    send(12'h040, 1'b1);
    chk(!s_mreq_v && !s_rsp_v && s_ready, "R7 miss with cancel dropped", 32'(s_mreq_v), 0);
    send(12'h005, 1'b1);
    chk(!s_rsp_v && !v_rsp_v, "R7 hit with cancel dropped", 32'(s_rsp_v), 0);
    wait_idle();
    chk(s_rsp_cnt == 0 && v_rsp_cnt == 0, "R7 no late response", s_rsp_cnt, 0);
  endtask

  task automatic t_cancel_in_request();
    send(12'h0C1, 1'b0);
    chk(s_mreq_v, "R3 miss request before cancel", 32'(s_mreq_v), 1);
    cancel = 1'b1; #1;
    chk(!s_mreq_v && !s_rsp_v, "R8 request withdrawn on cancel", 32'(s_mreq_v), 0);
    @(negedge clk); cancel = 1'b0;
    chk(s_ready, "R8 idle one cycle after cancel", 32'(s_ready), 1);
    wait_idle();
    chk(s_rsp_cnt == 0 && v_rsp_cnt == 0, "R6 canceled miss never responds",
        s_rsp_cnt + v_rsp_cnt, 0);
    check_snapshot("early cancel");
    send(12'h0C1, 1'b0);
    chk(s_mreq_v, "R8 canceled line still absent", 32'(s_mreq_v), 1);
    chk(v_rsp_v && v_rsp_d == mdata(12'h0C1), "R10 plain variant installed line",
        v_rsp_d, mdata(12'h0C1));
    wait_sec_rsp(12'h0C1, "R4 refill after cancel");
  endtask

  task automatic t_cancel_mid_fill();
    logic [ID_W-1:0] id0;
    send(12'h0EC, 1'b0);
    id0 = s_mreq_id;
    @(negedge clk);
    @(negedge clk); cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    chk(s_ready, "R8 idle after cancel with beat", 32'(s_ready), 1);
    wait_idle();
    chk(s_rsp_cnt == 0 && v_rsp_cnt == 0, "R6 mid-fill cancel no response",
        s_rsp_cnt + v_rsp_cnt, 0);
    check_snapshot("mid cancel");
    send(12'h0EC, 1'b0);
    chk(s_mreq_v && s_mreq_id != id0, "R8 new tag after cancel", 32'(s_mreq_id), 32'(id0 + 1'b1));
    chk(v_rsp_v && v_rsp_d == mdata(12'h0EC), "R10 plain variant completed fill",
        v_rsp_d, mdata(12'h0EC));
    wait_sec_rsp(12'h0EC, "R5 stale beats ignored, refill word");
  endtask

  task automatic t_foreign_beat();
    junk = 1'b1;
    do_miss(12'h0F5, 1, "R5 foreign tag beat");
    junk = 1'b0;
  endtask

  task automatic t_cancel_last_beat();
    send(12'h118, 1'b0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    @(negedge clk); cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    chk(s_ready && !s_rsp_v && !v_rsp_v, "R9 last beat loses to cancel", 32'(s_rsp_v), 0);
    wait_idle();
    chk(s_rsp_cnt == 0 && v_rsp_cnt == 0, "R10 no response after cancel", v_rsp_cnt, 0);
    send(12'h118, 1'b0);
    chk(s_mreq_v, "R9 line not installed", 32'(s_mreq_v), 1);
    chk(v_rsp_v && v_rsp_d == mdata(12'h118), "R10 line installed", v_rsp_d, mdata(12'h118));
    wait_sec_rsp(12'h118, "R4 refill after last-beat cancel");
  endtask

  task automatic t_cancel_hit_rsp();
    send(12'h013, 1'b0);
    cancel = 1'b1; #1;
    chk(!s_rsp_v && !v_rsp_v, "R6 hit response masked", 32'(s_rsp_v), 0);
    @(negedge clk); cancel = 1'b0;
    chk(!s_rsp_v && !v_rsp_v, "R6 masked hit not replayed", 32'(s_rsp_v), 0);
    check_snapshot("after all");
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_and_hit();
    t_req_with_cancel();
    t_cancel_in_request();
    t_cancel_mid_fill();
    t_foreign_beat();
    t_cancel_last_beat();
    t_cancel_hit_rsp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule